// File: doc/BRIEF.md
# Enhanced Sync Mode Controller

This block sits in the timing master of an image-sensor timing generator and interprets an external, active-low synchronization pin. It brings the pin into the pixel clock domain and finds its edges. From those edges it issues one-cycle reset strobes for the horizontal counter, the vertical counter and the field designator. It also issues field-advance strobes. While the pin is low it drives a set of level outputs. These mask the vertical, VD and HD outputs, freeze registers that are normally reloaded on VD, and hold the SCP0 output low.

A small control register selects one of three modes. The normal mode resets everything on the rising edge only. The hold mode, during the low interval, suspends the vertical outputs at their sequence-0 resting levels and stops SCP operation, while the horizontal timing runs on sequence-0 behaviour. The run mode leaves the vertical outputs running and can optionally mask HD. In both of these enhanced modes the counters are reset on each edge of the pin. Each edge also advances the field designator, unless the field mode is programmed for a single field.

Top module: `esync_ctrl`

## Requirements
- R1: With the enable bit clear, a rising edge of `sync_in` gives a one-cycle pulse on `hcnt_rst`, `vcnt_rst` and `fd_rst`. A falling edge gives no strobe, and every level output stays 0 while `sync_in` is low.
- R2: The hold mode is selected when the enable bit and the mask-V bit are both 1. In that mode, while `sync_in` is low, `v_hold`, `seq0_sel` and `scp_off` are 1 and `hd_mask` is 0.
- R3: The run mode is selected when the enable bit is 1 and the mask-V bit is 0. In that mode, while `sync_in` is low, `v_hold`, `seq0_sel` and `scp_off` are 0, and `hd_mask` equals the mask-HD bit.
- R4: `vd_mask` is 1 exactly while `sync_in` is low, an enhanced mode is active and the mask-VD bit is 1.
- R5: In either enhanced mode, both the falling and the rising edge of `sync_in` each give a one-cycle pulse on `hcnt_rst` and `vcnt_rst`, and `fd_rst` stays 0.
- R6: In either enhanced mode each edge of `sync_in` gives a one-cycle pulse on `fd_adv`, unless `single_field` is 1. In that case `fd_adv` stays 0. In the normal mode `fd_adv` is always 0.
- R7: In either enhanced mode `upd_inhibit` and `scp0_low` are 1 while `sync_in` is low. In all other cases they are 0.
- R8: A pulse on `cfg_load` captures four bits of `cfg_data`: bit 3 is the enable, bit 4 mask-V, bit 5 mask-VD and bit 6 mask-HD. Bits 7 and 2..0 are ignored. After reset the fields are enable 0, mask-V 1, mask-VD 1 and mask-HD 0.
- R9: Every output is registered and responds on the third rising clock edge after a change on `sync_in`, because of two synchronizer stages and one output stage. A new configuration applies to changes decided from the second edge after the `cfg_load` edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sync_in | input | 1 | Raw external sync pin, active low, asynchronous |
| cfg_load | input | 1 | Loads the control field from `cfg_data` |
| cfg_data | input | 8 | Control byte; bits 6..3 used |
| single_field | input | 1 | Field mode programmed for a single field |
| hcnt_rst | output | 1 | Horizontal counter reset strobe |
| vcnt_rst | output | 1 | Vertical counter reset strobe |
| fd_rst | output | 1 | Field designator reset strobe (normal mode) |
| fd_adv | output | 1 | Field designator advance and sequence-0 reload strobe |
| v_hold | output | 1 | Hold vertical outputs at sequence-0 start levels |
| seq0_sel | output | 1 | Horizontal and front-end clocks use sequence-0 behaviour |
| scp_off | output | 1 | Suspend SCP operation |
| vd_mask | output | 1 | Mask VD output |
| hd_mask | output | 1 | Mask HD output |
| scp0_low | output | 1 | Force SCP0 to 0 |
| upd_inhibit | output | 1 | Block VD-latched register updates |

## Verification
A change on `sync_in` is driven on a falling clock edge. Its strobes are expected on the third rising edge after it, so the bench waits three rising edges and samples on the following falling edge. It then samples one cycle later to confirm that each strobe lasted a single cycle and that the level outputs stayed set. A configuration write is followed by at least three idle cycles before any sync edge, so each edge is decided with the new mode. The full output vector is compared against a value computed from the mode bits, the sync level and the edge type.

// File: rtl/esync_pkg.sv
package esync_pkg;

  typedef struct packed {
    logic mask_hd;
    logic mask_vd;
    logic mask_v;
    logic enh;
  } esync_cfg_t;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0,
    MODE_HOLD   = 2'd1,
    MODE_RUN    = 2'd2
  } esync_mode_e;

  localparam esync_cfg_t CFG_RESET = '{mask_hd: 1'b0, mask_vd: 1'b1,
                                       mask_v: 1'b1, enh: 1'b0};

  function automatic esync_mode_e decode_mode(esync_cfg_t c);
    if (!c.enh)       return MODE_NORMAL;
    else if (c.mask_v) return MODE_HOLD;
    else              return MODE_RUN;
  endfunction

endpackage

// File: rtl/esync_sync.sv
module esync_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_raw_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;
  logic              prev_q;
  logic              prev_d;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_comb chain_d[i] = sync_raw_i;
      end else begin : g_rest
        always_comb chain_d[i] = chain_q[i-1];
      end
    end
  endgenerate

  always_comb prev_d = chain_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '1;
      prev_q  <= 1'b1;
    end else begin
      chain_q <= chain_d;
      prev_q  <= prev_d;
    end
  end

  always_comb begin
    lvl_o  = chain_q[STAGES-1];
    rise_o = chain_q[STAGES-1] & ~prev_q;
    fall_o = ~chain_q[STAGES-1] & prev_q;
  end

endmodule

// File: rtl/esync_cfg.sv
module esync_cfg
  import esync_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int FIELD_LSB = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  output esync_cfg_t        cfg_o
);

  localparam int FIELD_W = $bits(esync_cfg_t);

  esync_cfg_t cfg_q;
  esync_cfg_t cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (load_i) cfg_d = esync_cfg_t'(data_i[FIELD_LSB +: FIELD_W]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= CFG_RESET;
    else        cfg_q <= cfg_d;
  end

  assign cfg_o = cfg_q;

  AST_CFG_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(cfg_q)); // R8

endmodule

// File: rtl/esync_strobe.sv
module esync_strobe
  import esync_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rise_i,
  input  logic       fall_i,
  input  esync_cfg_t cfg_i,
  input  logic       single_field_i,
  output logic       hcnt_rst_o,
  output logic       vcnt_rst_o,
  output logic       fd_rst_o,
  output logic       fd_adv_o
);

  logic hrst_d, vrst_d, fdr_d, fda_d;
  logic hrst_q, vrst_q, fdr_q, fda_q;
  logic any_edge;
  esync_mode_e mode;

  always_comb begin
    mode     = decode_mode(cfg_i);
    any_edge = rise_i | fall_i;
    hrst_d   = 1'b0;
    vrst_d   = 1'b0;
    fdr_d    = 1'b0;
    fda_d    = 1'b0;
    unique case (mode)
      MODE_NORMAL: begin
        hrst_d = rise_i;
        vrst_d = rise_i;
        fdr_d  = rise_i;
      end
      MODE_HOLD, MODE_RUN: begin
        hrst_d = any_edge;
        vrst_d = any_edge;
        fda_d  = any_edge & ~single_field_i;
      end
      default: begin
        hrst_d = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hrst_q <= 1'b0;
      vrst_q <= 1'b0;
      fdr_q  <= 1'b0;
      fda_q  <= 1'b0;
    end else begin
      hrst_q <= hrst_d;
      vrst_q <= vrst_d;
      fdr_q  <= fdr_d;
      fda_q  <= fda_d;
    end
  end

  assign hcnt_rst_o = hrst_q;
  assign vcnt_rst_o = vrst_q;
  assign fd_rst_o   = fdr_q;
  assign fd_adv_o   = fda_q;

  AST_FALL_IGNORED_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_i && !cfg_i.enh) |=> !hcnt_rst_o); // R1
  AST_FDRST_FROM_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    fd_rst_o |-> $past(rise_i)); // R1
  AST_FDADV_NOT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    fd_adv_o |-> !$past(single_field_i)); // R6
  AST_ENH_NO_FDRST: assert property (@(posedge clk) disable iff (!rst_n)
    fd_adv_o |-> !fd_rst_o); // R5

endmodule

// File: rtl/esync_mask.sv
module esync_mask
  import esync_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lvl_i,
  input  esync_cfg_t cfg_i,
  output logic       v_hold_o,
  output logic       seq0_sel_o,
  output logic       scp_off_o,
  output logic       vd_mask_o,
  output logic       hd_mask_o,
  output logic       scp0_low_o,
  output logic       upd_inhibit_o
);

  typedef struct packed {
    logic v_hold;
    logic seq0_sel;
    logic scp_off;
    logic vd_mask;
    logic hd_mask;
    logic scp0_low;
    logic upd_inhibit;
  } mask_t;

  mask_t       mask_d, mask_q;
  esync_mode_e mode;
  logic        in_low;

  always_comb begin
    mode   = decode_mode(cfg_i);
    in_low = ~lvl_i;
    mask_d = '0;
    if (in_low) begin
      unique case (mode)
        MODE_HOLD: begin
          mask_d.v_hold      = 1'b1;
          mask_d.seq0_sel    = 1'b1;
          mask_d.scp_off     = 1'b1;
          mask_d.vd_mask     = cfg_i.mask_vd;
          mask_d.scp0_low    = 1'b1;
          mask_d.upd_inhibit = 1'b1;
        end
        MODE_RUN: begin
          mask_d.vd_mask     = cfg_i.mask_vd;
          mask_d.hd_mask     = cfg_i.mask_hd;
          mask_d.scp0_low    = 1'b1;
          mask_d.upd_inhibit = 1'b1;
        end
        default: begin
          mask_d = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_d;
  end

  assign v_hold_o      = mask_q.v_hold;
  assign seq0_sel_o    = mask_q.seq0_sel;
  assign scp_off_o     = mask_q.scp_off;
  assign vd_mask_o     = mask_q.vd_mask;
  assign hd_mask_o     = mask_q.hd_mask;
  assign scp0_low_o    = mask_q.scp0_low;
  assign upd_inhibit_o = mask_q.upd_inhibit;

  AST_VHOLD_INHIBITS: assert property (@(posedge clk) disable iff (!rst_n)
    v_hold_o |-> upd_inhibit_o); // R2
  AST_HDMASK_RUN_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    hd_mask_o |-> !v_hold_o); // R3
  AST_VDMASK_IN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    vd_mask_o |-> scp0_low_o); // R4
  AST_LEVEL_FROM_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    upd_inhibit_o |-> !$past(lvl_i)); // R7

endmodule

// File: rtl/esync_ctrl.sv
module esync_ctrl
  import esync_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CFG_W       = 8,
  parameter int CFG_LSB     = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_in,
  input  logic             cfg_load,
  input  logic [CFG_W-1:0] cfg_data,
  input  logic             single_field,
  output logic             hcnt_rst,
  output logic             vcnt_rst,
  output logic             fd_rst,
  output logic             fd_adv,
  output logic             v_hold,
  output logic             seq0_sel,
  output logic             scp_off,
  output logic             vd_mask,
  output logic             hd_mask,
  output logic             scp0_low,
  output logic             upd_inhibit
);

  logic       sync_lvl, sync_rise, sync_fall;
  esync_cfg_t cfg;

  esync_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .sync_raw_i (sync_in),
    .lvl_o      (sync_lvl),
    .rise_o     (sync_rise),
    .fall_o     (sync_fall)
  );

  esync_cfg #(.DATA_W(CFG_W), .FIELD_LSB(CFG_LSB)) u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (cfg_load),
    .data_i (cfg_data),
    .cfg_o  (cfg)
  );

  esync_strobe u_strobe (
    .clk            (clk),
    .rst_n          (rst_n),
    .rise_i         (sync_rise),
    .fall_i         (sync_fall),
    .cfg_i          (cfg),
    .single_field_i (single_field),
    .hcnt_rst_o     (hcnt_rst),
    .vcnt_rst_o     (vcnt_rst),
    .fd_rst_o       (fd_rst),
    .fd_adv_o       (fd_adv)
  );

  esync_mask u_mask (
    .clk           (clk),
    .rst_n         (rst_n),
    .lvl_i         (sync_lvl),
    .cfg_i         (cfg),
    .v_hold_o      (v_hold),
    .seq0_sel_o    (seq0_sel),
    .scp_off_o     (scp_off),
    .vd_mask_o     (vd_mask),
    .hd_mask_o     (hd_mask),
    .scp0_low_o    (scp0_low),
    .upd_inhibit_o (upd_inhibit)
  );

  AST_NO_STROBE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (hcnt_rst && !$past(sync_rise)) |-> $past(sync_fall)); // R9

endmodule

// File: tb/tb_esync_ctrl.sv
module tb_esync_ctrl;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync_in = 1'b1;
  logic cfg_load = 1'b0;
  logic [7:0] cfg_data = 8'h00;
  logic single_field = 1'b0;
  logic hcnt_rst, vcnt_rst, fd_rst, fd_adv, v_hold, seq0_sel, scp_off;
  logic vd_mask, hd_mask, scp0_low, upd_inhibit;

  int nvec = 0;
  int nerr = 0;

  always #2 clk = ~clk;

  esync_ctrl dut (
    .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .cfg_load(cfg_load),
    .cfg_data(cfg_data), .single_field(single_field),
    .hcnt_rst(hcnt_rst), .vcnt_rst(vcnt_rst), .fd_rst(fd_rst), .fd_adv(fd_adv),
    .v_hold(v_hold), .seq0_sel(seq0_sel), .scp_off(scp_off),
    .vd_mask(vd_mask), .hd_mask(hd_mask), .scp0_low(scp0_low),
    .upd_inhibit(upd_inhibit)
  );

  // model state: enable, mask-V, mask-VD, mask-HD (R8 field bits 3..6)
  logic m_enh, m_mv, m_mvd, m_mhd;

  function automatic logic [10:0] expv(logic rise, logic fall, logic low);
    logic enh_hold, enh_run;
    logic [10:0] v;
    enh_hold = m_enh & m_mv;
    enh_run  = m_enh & ~m_mv;
    v = '0;
    v[10] = m_enh ? (rise | fall) : rise;               // hcnt_rst R1/R5
    v[9]  = v[10];                                      // vcnt_rst
    v[8]  = ~m_enh & rise;                              // fd_rst
    v[7]  = m_enh & (rise | fall) & ~single_field;      // fd_adv R6
    v[6]  = low & enh_hold;                             // v_hold R2
    v[5]  = low & enh_hold;                             // seq0_sel
    v[4]  = low & enh_hold;                             // scp_off
    v[3]  = low & m_enh & m_mvd;                        // vd_mask R4
    v[2]  = low & enh_run & m_mhd;                      // hd_mask R3
    v[1]  = low & m_enh;                                // scp0_low R7
    v[0]  = low & m_enh;                                // upd_inhibit
    return v;
  endfunction

  function automatic logic [10:0] obs();
    return {hcnt_rst, vcnt_rst, fd_rst, fd_adv, v_hold, seq0_sel, scp_off,
            vd_mask, hd_mask, scp0_low, upd_inhibit};
  endfunction

  task automatic chk(string tag, logic [10:0] exp);
    nvec++;
    if (obs() !== exp) begin
      nerr++;
      $display("FAIL %s: got %b expected %b", tag, obs(), exp);
    end
  endtask

  task automatic wr_cfg(logic [7:0] d);
    @(negedge clk);
    cfg_data = d;
    cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
    m_enh = d[3]; m_mv = d[4]; m_mvd = d[5]; m_mhd = d[6];
    repeat (3) @(negedge clk);
  endtask

  // drive an edge on sync_in, check strobe cycle, then next cycle (R9)
  task automatic sync_edge(string tag, logic val);
    @(negedge clk);
    sync_in = val;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(tag, expv(val, ~val, ~val));
    @(negedge clk);
    chk(tag, expv(1'b0, 1'b0, ~val));
  endtask

  task automatic t_reset;
    m_enh = 1'b0; m_mv = 1'b1; m_mvd = 1'b1; m_mhd = 1'b0;
    chk("R8 reset outputs", 11'b0);
  endtask

  task automatic t_normal;
    sync_edge("R1 normal fall", 1'b0);
    repeat (4) @(negedge clk);
    chk("R1 normal low level", expv(1'b0, 1'b0, 1'b1));
    sync_edge("R1 normal rise", 1'b1);
  endtask

  task automatic t_hold_reset_cfg;
    // reset mask fields kept: only bit 3 set plus mask-V 1, mask-VD 1
    wr_cfg(8'b0011_1000);
    sync_edge("R2 R5 R6 hold fall", 1'b0);
    sync_edge("R2 R5 R6 hold rise", 1'b1);
  endtask

  task automatic t_run;
    wr_cfg(8'b0100_1000); // run, mask-VD 0, mask-HD 1
    sync_edge("R3 R4 R7 run fall", 1'b0);
    sync_edge("R3 R5 run rise", 1'b1);
    wr_cfg(8'b0010_1000); // run, mask-VD 1, mask-HD 0
    sync_edge("R3 R4 run nohd fall", 1'b0);
    sync_edge("R3 run nohd rise", 1'b1);
  endtask

  task automatic t_single;
    wr_cfg(8'b0011_1000);
    single_field = 1'b1;
    sync_edge("R6 single fall", 1'b0);
    sync_edge("R6 single rise", 1'b1);
    single_field = 1'b0;
  endtask

  task automatic t_ignored_bits;
    wr_cfg(8'b1000_0111); // enable 0 in bit 3; other set bits ignored
    sync_edge("R8 ignored bits fall", 1'b0);
    sync_edge("R8 ignored bits rise", 1'b1);
  endtask

  task automatic t_normal_single;
    single_field = 1'b1;
    sync_edge("R6 normal no adv fall", 1'b0);
    sync_edge("R6 normal no adv rise", 1'b1);
    single_field = 1'b0;
  endtask

  initial begin
    m_enh = 1'b0; m_mv = 1'b1; m_mvd = 1'b1; m_mhd = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8 idle after reset", 11'b0);
    t_normal();
    t_hold_reset_cfg();
    t_run();
    t_single();
    t_ignored_bits();
    t_normal_single();
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

endmodule